// File: doc/BRIEF.md
# Six-Channel Edge-Placed PWM Output Stage

This block generates six pulse-width-modulated pin outputs from one shared up-counter. The counter runs from zero to a programmable modulus minus one and then returns to zero. Each channel owns a pair of compare values that mark the start and the end of its active window on that counter. A per-channel invert bit makes the channel active outside the window instead of inside it. New compare values, invert bits and a new modulus are held in shadow registers. They are copied into the working set only when the counter wraps, so every period is built from one consistent set of values.

Channels are grouped in pairs. The even channels (0, 2, 4) form the top group and the odd channels (1, 3, 5) form the bottom group. Each group has a single negative-polarity bit. When that bit is set, the group's pins are low while a channel is active. Any channel can be switched to software drive, where a software bit decides whether the channel is active. The group polarity bit still applies to a channel under software drive.

All settings arrive through one write port. Every pin comes straight from a flip-flop.

The timebase is a two-state machine:
- `TB_STOP` holds the counter at zero and copies the shadow set into the working set on every cycle. It leaves for `TB_COUNT` (transition *start*) once the shadow modulus is non-zero.
- `TB_COUNT` advances the counter by one (transition *step*). At the last count it returns the counter to zero and loads the shadow set (transition *wrap*). If the shadow modulus is zero at that point it goes back to `TB_STOP` (transition *halt*).

Each output slot picks its source with a two-value selector, `SRC_GEN` or `SRC_SW`.

Top module: `pwm6_out_stage`

## Requirements
- R1: While reset is held and after it is released with no writes, all six pins are 0: the counter is stopped, software drive is off for every channel and both polarity bits are 0 (positive).
- R2: With working modulus M > 0, the counter takes the values 0, 1, …, M-1 and then 0 again. A modulus of 9 gives a period of 9 cycles. Address 0, bits [7:0], is the modulus.
- R3: With the channel's invert bit at 0, channel k is active while first ≤ count < second. If first ≥ second the channel is never active. Address 1+k holds the first compare value in bits [7:0] and the second in bits [15:8]. A pin shows, one clock later, the state computed from the counter value of the previous cycle.
- R4: With the channel's invert bit at 1, the channel is active exactly when the R3 condition is false. Address 7, bit k, is channel k's invert bit.
- R5: Writes to compare values, invert bits and the modulus change the waveform only from the cycle in which the counter returns to 0. The period under way is finished with the old values.
- R6: Address 8 bit 0 is the top-group polarity bit. When it is set, pins 0, 2 and 4 are low while active and high while inactive.
- R7: Address 8 bit 1 is the bottom-group polarity bit. When it is set, pins 1, 3 and 5 are low while active and high while inactive.
- R8: Address 9 bit k enables software drive of channel k, and bit 8+k is its software output bit. While software drive is enabled, the channel is active exactly when the software bit is 1, one clock after the register holds it.
- R9: The group polarity bits apply in the same way to channels under software drive.
- R10: A working modulus of 0 stops the counter at 0 and makes every channel driven by the generator inactive. Writing a non-zero modulus restarts counting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the settings port |
| wr_addr | input | 4 | Setting address |
| wr_data | input | 16 | Setting value |
| pwm_o | output | 6 | Registered pin outputs, bit k is channel k |

## Verification
A counter that skips a value, or that wraps one count early or late, shifts every generator-driven edge. The scoreboard catches this at the pins within one period of the modulus. If the working compare set is loaded at the wrong moment, the waveform changes in the middle of a period. That mismatch shows up in the cycle the counter crosses the changed compare value, which is at most one period after the write. A wrong source selection or a wrong polarity group flips the affected pin one clock after the setting is written.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;

    // Default geometry of the stage
    localparam int unsigned PWM_NCH = 6;
    localparam int unsigned PWM_CW  = 8;
    localparam int unsigned PWM_DW  = 16;
    localparam int unsigned PWM_AW  = 4;

    // Address of the modulus; channel compare pairs follow it
    localparam int unsigned ADDR_MOD     = 0;
    localparam int unsigned ADDR_CH_BASE = 1;

    // Timebase states
    typedef enum logic {
        TB_STOP  = 1'b0,
        TB_COUNT = 1'b1
    } tb_state_e;

    // Output source per channel
    typedef enum logic {
        SRC_GEN = 1'b0,
        SRC_SW  = 1'b1
    } src_sel_e;

endpackage

// File: rtl/pwm6_regfile.sv
module pwm6_regfile
    import pwm6_pkg::*;
#(
    parameter int unsigned NCH = PWM_NCH,
    parameter int unsigned CW  = PWM_CW,
    parameter int unsigned DW  = PWM_DW,
    parameter int unsigned AW  = PWM_AW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    output logic [CW-1:0]           sh_mod,
    output logic [NCH-1:0][CW-1:0]  sh_lo,
    output logic [NCH-1:0][CW-1:0]  sh_hi,
    output logic [NCH-1:0]          sh_inv,
    output logic                    pol_top,
    output logic                    pol_bot,
    output logic [NCH-1:0]          ovr_en,
    output logic [NCH-1:0]          sw_out
);

    localparam int unsigned ADDR_INV = ADDR_CH_BASE + NCH;
    localparam int unsigned ADDR_POL = ADDR_INV + 1;
    localparam int unsigned ADDR_OVR = ADDR_INV + 2;
    localparam int unsigned HI_LSB   = DW / 2;
    localparam int unsigned SW_LSB   = DW / 2;

    logic hit_mod, hit_inv, hit_pol, hit_ovr;

    always_comb begin
        hit_mod = wr_en && (wr_addr == AW'(ADDR_MOD));
        hit_inv = wr_en && (wr_addr == AW'(ADDR_INV));
        hit_pol = wr_en && (wr_addr == AW'(ADDR_POL));
        hit_ovr = wr_en && (wr_addr == AW'(ADDR_OVR));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_mod <= '0;
        end else if (hit_mod) begin
            sh_mod <= wr_data[CW-1:0];
        end
    end

    // One compare pair per channel
    for (genvar k = 0; k < NCH; k++) begin : g_cmp
        logic hit_ch;
        assign hit_ch = wr_en && (wr_addr == AW'(ADDR_CH_BASE + k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_lo[k] <= '0;
                sh_hi[k] <= '0;
            end else if (hit_ch) begin
                sh_lo[k] <= wr_data[CW-1:0];
                sh_hi[k] <= wr_data[HI_LSB +: CW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_inv  <= '0;
            pol_top <= 1'b0;
            pol_bot <= 1'b0;
            ovr_en  <= '0;
            sw_out  <= '0;
        end else begin
            if (hit_inv) begin
                sh_inv <= wr_data[NCH-1:0];
            end
            if (hit_pol) begin
                pol_top <= wr_data[0];
                pol_bot <= wr_data[1];
            end
            if (hit_ovr) begin
                ovr_en <= wr_data[NCH-1:0];
                sw_out <= wr_data[SW_LSB +: NCH];
            end
        end
    end

endmodule

// File: rtl/pwm6_timebase.sv
module pwm6_timebase
    import pwm6_pkg::*;
#(
    parameter int unsigned CW = PWM_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] sh_mod,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] act_mod,
    output logic          load,
    output logic          running
);

    tb_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] mod_q;
    logic          load_d;
    logic          last_cnt;

    assign last_cnt = (cnt_q == (mod_q - CW'(1)));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load_d  = 1'b0;
        unique case (state_q)
            TB_STOP: begin
                load_d = 1'b1;
                cnt_d  = '0;
                if (sh_mod != '0) begin
                    state_d = TB_COUNT;          // start
                end
            end
            TB_COUNT: begin
                if (last_cnt) begin
                    cnt_d  = '0;                 // wrap
                    load_d = 1'b1;
                    if (sh_mod == '0) begin
                        state_d = TB_STOP;       // halt
                    end
                end else begin
                    cnt_d = cnt_q + CW'(1);      // step
                end
            end
            default: begin
                state_d = TB_STOP;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TB_STOP;
            cnt_q   <= '0;
            mod_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (load_d) begin
                mod_q <= sh_mod;
            end
        end
    end

    // Outputs
    always_comb begin
        cnt     = cnt_q;
        act_mod = mod_q;
        load    = load_d;
        running = (state_q == TB_COUNT);
    end

endmodule

// File: rtl/pwm6_channel.sv
module pwm6_channel
    import pwm6_pkg::*;
#(
    parameter int unsigned CW = PWM_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          running,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] sh_lo,
    input  logic [CW-1:0] sh_hi,
    input  logic          sh_inv,
    output logic          gen_act
);

    logic [CW-1:0] lo_q, hi_q;
    logic          inv_q;
    logic          in_win;

    // Working compare set, refreshed only on a load from the timebase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            inv_q <= 1'b0;
        end else if (load) begin
            lo_q  <= sh_lo;
            hi_q  <= sh_hi;
            inv_q <= sh_inv;
        end
    end

    always_comb begin
        in_win  = (cnt >= lo_q) && (cnt < hi_q);
        gen_act = running && (in_win ^ inv_q);
    end

endmodule

// File: rtl/pwm6_out_stage.sv
module pwm6_out_stage
    import pwm6_pkg::*;
#(
    parameter int unsigned NCH = PWM_NCH,
    parameter int unsigned CW  = PWM_CW,
    parameter int unsigned DW  = PWM_DW,
    parameter int unsigned AW  = PWM_AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    output logic [NCH-1:0] pwm_o
);

    logic [CW-1:0]          sh_mod;
    logic [NCH-1:0][CW-1:0] sh_lo, sh_hi;
    logic [NCH-1:0]         sh_inv;
    logic                   pol_top, pol_bot;
    logic [NCH-1:0]         ovr_en, sw_out;
    logic [CW-1:0]          tb_cnt, tb_mod;
    logic                   tb_load, tb_running;
    logic [NCH-1:0]         gen_act;
    logic [NCH-1:0]         grp_neg;

    pwm6_regfile #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sh_mod  (sh_mod),
        .sh_lo   (sh_lo),
        .sh_hi   (sh_hi),
        .sh_inv  (sh_inv),
        .pol_top (pol_top),
        .pol_bot (pol_bot),
        .ovr_en  (ovr_en),
        .sw_out  (sw_out)
    );

    pwm6_timebase #(.CW(CW)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .sh_mod  (sh_mod),
        .cnt     (tb_cnt),
        .act_mod (tb_mod),
        .load    (tb_load),
        .running (tb_running)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        src_sel_e src;
        logic     chan_act;
        logic     pin_q;

        pwm6_channel #(.CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (tb_load),
            .running (tb_running),
            .cnt     (tb_cnt),
            .sh_lo   (sh_lo[k]),
            .sh_hi   (sh_hi[k]),
            .sh_inv  (sh_inv[k]),
            .gen_act (gen_act[k])
        );

        // Even channels form the top group, odd ones the bottom group
        if ((k % 2) == 0) begin : g_top
            assign grp_neg[k] = pol_top;
        end else begin : g_bot
            assign grp_neg[k] = pol_bot;
        end

        always_comb begin
            src = ovr_en[k] ? SRC_SW : SRC_GEN;
            unique case (src)
                SRC_SW:  chan_act = sw_out[k];
                SRC_GEN: chan_act = gen_act[k];
                default: chan_act = 1'b0;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pin_q <= 1'b0;
            end else begin
                pin_q <= chan_act ^ grp_neg[k];
            end
        end

        assign pwm_o[k] = pin_q;
    end

endmodule

// File: rtl/pwm6_out_checker.sv
module pwm6_out_checker #(
    parameter int unsigned NCH = 6,
    parameter int unsigned CW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           running,
    input logic [CW-1:0]  cnt,
    input logic [CW-1:0]  act_mod,
    input logic [NCH-1:0] pwm_o,
    input logic [NCH-1:0] ovr_en,
    input logic [NCH-1:0] sw_out,
    input logic [NCH-1:0] gen_act,
    input logic [NCH-1:0] grp_neg
);

    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < act_mod));

    assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (cnt == (act_mod - CW'(1)))) |=> (cnt == '0));

    assert_mod_only_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_mod) |-> (cnt == '0));

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> ((cnt == '0) && (gen_act == '0)));

    for (genvar k = 0; k < NCH; k++) begin : g_pin
        assert_sw_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ovr_en[k] |=> (pwm_o[k] == ($past(sw_out[k]) ^ $past(grp_neg[k]))));

        assert_gen_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !ovr_en[k] |=> (pwm_o[k] == ($past(gen_act[k]) ^ $past(grp_neg[k]))));
    end

endmodule

bind pwm6_out_stage pwm6_out_checker #(.NCH(NCH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (tb_running),
    .cnt     (tb_cnt),
    .act_mod (tb_mod),
    .pwm_o   (pwm_o),
    .ovr_en  (ovr_en),
    .sw_out  (sw_out),
    .gen_act (gen_act),
    .grp_neg (grp_neg)
);

// File: tb/tb_pwm6_out_stage.sv
`timescale 1ns/1ps
module tb_pwm6_out_stage;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  pwm_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    pwm6_out_stage dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm_o)
    );

    always #(HALF) clk = ~clk;

    // Reference state built from the requirements
    int       m_cnt, m_mod, s_mod;
    bit       m_run;
    int       m_lo[6], m_hi[6], s_lo[6], s_hi[6];
    bit [5:0] m_inv, s_inv, m_oen, m_sw;
    bit       m_ptop, m_pbot;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mod = 0; s_mod = 0; m_run = 0;
            m_inv = '0; s_inv = '0; m_oen = '0; m_sw = '0;
            m_ptop = 0; m_pbot = 0;
            for (int k = 0; k < 6; k++) begin
                m_lo[k] = 0; m_hi[k] = 0; s_lo[k] = 0; s_hi[k] = 0;
            end
        end else begin
            logic [5:0] e;
            for (int k = 0; k < 6; k++) begin
                bit win, act, v;
                win = (m_cnt >= m_lo[k]) && (m_cnt < m_hi[k]);
                act = m_run && (win ^ m_inv[k]);
                v   = m_oen[k] ? m_sw[k] : act;
                e[k] = v ^ (((k % 2) == 0) ? m_ptop : m_pbot);
            end
            exp_q.push_back(e);
            tag_q.push_back(cur_req);
            // counter and load, using values held before this edge
            if (!m_run || (m_cnt == m_mod - 1)) begin
                m_cnt = 0;
                m_mod = s_mod;
                m_inv = s_inv;
                for (int k = 0; k < 6; k++) begin
                    m_lo[k] = s_lo[k]; m_hi[k] = s_hi[k];
                end
                m_run = (s_mod != 0);
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (wr_en) begin
                case (wr_addr)
                    4'd0: s_mod = int'(wr_data[7:0]);
                    4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: begin
                        s_lo[wr_addr - 1] = int'(wr_data[7:0]);
                        s_hi[wr_addr - 1] = int'(wr_data[15:8]);
                    end
                    4'd7: s_inv = wr_data[5:0];
                    4'd8: begin m_ptop = wr_data[0]; m_pbot = wr_data[1]; end
                    4'd9: begin m_oen = wr_data[5:0]; m_sw = wr_data[13:8]; end
                    default: ;
                endcase
            end
        end
    end

    // Monitor: compare pins against the scoreboard away from the edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [5:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (pwm_o !== e) begin
                errors++;
                $display("FAIL %s: pwm_o=%b expected %b at %0t", t, pwm_o, e, $time);
            end
        end
    end

    task automatic write_reg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(HALF * 2 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: pins low during reset
        idle(3);
        checks++;
        if (pwm_o !== 6'b0) begin
            errors++;
            $display("FAIL R1: pwm_o=%b expected %b", pwm_o, 6'b0);
        end
        rst_n = 1'b1;
        cur_req = "R1";
        idle(6);

        // R10: stopped counter while modulus is 0, compares present
        cur_req = "R10";
        write_reg(4'd1, {8'd6, 8'd0});
        idle(5);

        // R3: window compares, modulus 9
        cur_req = "R3";
        write_reg(4'd1, {8'd6, 8'd3});
        write_reg(4'd2, {8'd7, 8'd3});
        write_reg(4'd3, {8'd9, 8'd0});
        write_reg(4'd4, {8'd2, 8'd5});   // empty window
        write_reg(4'd5, {8'd9, 8'd5});
        write_reg(4'd6, {8'd8, 8'd7});
        write_reg(4'd0, 16'd9);
        idle(30);

        // R2: period follows the modulus
        cur_req = "R2";
        write_reg(4'd0, 16'd4);
        idle(20);
        write_reg(4'd0, 16'd1);
        idle(8);
        write_reg(4'd0, 16'd9);
        idle(20);

        // R4: inverted windows
        cur_req = "R4";
        write_reg(4'd7, 16'b101110);
        idle(30);

        // R5: mid-period changes wait for the wrap
        cur_req = "R5";
        idle(2);
        write_reg(4'd1, {8'd8, 8'd1});
        write_reg(4'd7, 16'b010001);
        idle(12);
        write_reg(4'd0, 16'd5);
        idle(15);
        write_reg(4'd0, 16'd9);
        idle(20);

        // R6 / R7: group polarity
        cur_req = "R6";
        write_reg(4'd8, 16'd1);
        idle(20);
        cur_req = "R7";
        write_reg(4'd8, 16'd2);
        idle(20);
        write_reg(4'd8, 16'd3);
        idle(10);
        write_reg(4'd8, 16'd0);
        idle(4);

        // R8: software drive
        cur_req = "R8";
        write_reg(4'd9, {2'b00, 6'b010001, 2'b00, 6'b110011});
        idle(5);
        write_reg(4'd9, {2'b00, 6'b100010, 2'b00, 6'b110011});
        idle(3);
        write_reg(4'd9, {2'b00, 6'b111111, 2'b00, 6'b111111});
        idle(3);
        write_reg(4'd9, {2'b00, 6'b111111, 2'b00, 6'b000000});
        idle(12);

        // R9: polarity under software drive
        cur_req = "R9";
        write_reg(4'd9, {2'b00, 6'b001100, 2'b00, 6'b111111});
        write_reg(4'd8, 16'd3);
        idle(5);
        write_reg(4'd8, 16'd1);
        idle(5);
        write_reg(4'd8, 16'd2);
        idle(5);
        write_reg(4'd9, 16'd0);
        write_reg(4'd8, 16'd0);
        idle(5);

        // R10: stop and restart
        cur_req = "R10";
        write_reg(4'd0, 16'd0);
        idle(20);
        write_reg(4'd7, 16'd0);
        write_reg(4'd0, 16'd5);
        idle(20);

        idle(2);
        finish_run();
    end

endmodule